// File: doc/BRIEF.md
# Built-In Self-Test Step Sequencer

This block schedules the self-test conversions that a converter runs on itself. There are two fixed programs. The supply program has three steps, numbered 0 to 2. The capacitive program has twelve steps, numbered 3 to 14. The sequencer raises a request together with a step number. It holds both until the converter returns a one-cycle done pulse.

In one-shot mode, software picks a single step, and each start command runs exactly that step once. In scan mode, the steps advance by themselves and repeat while the start input stays high. The scan runs either the supply program alone or the supply program followed by the capacitive program. Software reads a sticky end-of-conversion flag and clears it by writing 1. A completion timer flags a sequence that does not reach its final done pulse within a programmed number of cycles. A self-test enable input gates all activity, and dropping it aborts whatever is running.

Top module: `bist_step_sequencer`

## Requirements
- R1: After reset, `conv_req`, `eoc_flag` and `wdog_err` are 0.
- R2: Steps are encoded on `conv_step`: supply steps 0, 1, 2 and capacitive steps 3 to 14. While a conversion is pending and no done pulse arrives, `conv_req` stays 1 and `conv_step` holds its value.
- R3: In one-shot mode (`scan_mode`=0), if `st_en`=1, `st_start`=1, the block is idle and `step_sel` is between 0 and 14, then `conv_req` rises on the next cycle with `conv_step`=`step_sel`. The cycle after the done pulse, `conv_req` is 0.
- R4: In one-shot mode, a start with `step_sel`=15 is ignored, and `conv_req` stays 0.
- R5: In scan mode with `alg_with_cap`=0, the requested steps are 0, 1, 2, 0, 1, … with one step per done pulse.
- R6: In scan mode with `alg_with_cap`=1, the requested steps are 0 through 14, then 0 again.
- R7: In scan mode, if `st_start` is 0 when a done pulse arrives, `conv_req` is 0 on the next cycle.
- R8: While `st_en` is 0, starts are ignored. Dropping `st_en` during a conversion clears `conv_req` and `wdog_err` one cycle later.
- R9: `eoc_flag` sets one cycle after an accepted done pulse. It clears one cycle after `eoc_clr`=1. If both happen in the same cycle, the set wins.
- R10: A start command, or a change of `step_sel`, while a conversion is pending does not change `conv_step` and does not cause a second conversion.
- R11: The timer reloads to `wdog_limit` at every sequence start. A sequence start is a launch from idle, or a scan wrap back to step 0. If the final done pulse of the sequence has not been sampled by L clock edges after the start edge, `wdog_err` rises at edge L+1. The final done pulse is any done pulse in one-shot mode, or the last step in scan mode. A limit of 0 disables the timer. `wdog_err` is sticky until `st_en` is 0.
- R12: A done pulse while no conversion is pending has no effect: `eoc_flag` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| st_en | input | 1 | Self-test enable; low aborts and clears the timer error |
| st_start | input | 1 | Start command (one-shot) / run level (scan) |
| scan_mode | input | 1 | 1 = scan mode, 0 = one-shot |
| alg_with_cap | input | 1 | Scan program: 0 = supply only, 1 = supply then capacitive |
| step_sel | input | 4 | One-shot step number (0..14) |
| eoc_clr | input | 1 | Write-1 clear of the end-of-conversion flag |
| wdog_limit | input | 16 | Timer period in cycles, 0 disables |
| conv_done | input | 1 | One-cycle done pulse from the converter |
| conv_req | output | 1 | Conversion request, held until done |
| conv_step | output | 4 | Step number of the requested conversion |
| eoc_flag | output | 1 | Sticky end-of-conversion flag |
| wdog_err | output | 1 | Sequence completion timeout |

## Verification
A corrupted step register shows on `conv_step` at the very next sampled request. A scan order that skips, repeats or wraps at the wrong point diverges from the expected sequence within one done pulse. A controller stuck in the pending state shows as `conv_req` still high one cycle after a done pulse or after an abort. A timer that reloads wrongly shows as `wdog_err` rising one cycle early or late against the exact edge L+1, or as a spurious error after an in-time completion.

// File: rtl/bist_seq_pkg.sv
package bist_seq_pkg;
  typedef enum logic {
    SQ_IDLE = 1'b0,
    SQ_CONV = 1'b1
  } seq_state_e;
endpackage

// File: rtl/bist_seq_rstsync.sv
module bist_seq_rstsync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_n = sync_q[1];
endmodule

// File: rtl/bist_seq_ctrl.sv
module bist_seq_ctrl
  import bist_seq_pkg::*;
#(
  parameter int N_SUPPLY = 3,
  parameter int N_CAP    = 12,
  parameter int STEP_W   = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              st_en,
  input  logic              st_start,
  input  logic              scan_mode,
  input  logic              alg_with_cap,
  input  logic [STEP_W-1:0] step_sel,
  input  logic              conv_done,
  output logic              conv_req,
  output logic [STEP_W-1:0] conv_step,
  output logic              done_acc,
  output logic              seq_start,
  output logic              seq_end
);
  localparam int TOTAL = N_SUPPLY + N_CAP;
  localparam logic [STEP_W-1:0] LAST_SUP = STEP_W'(N_SUPPLY - 1);
  localparam logic [STEP_W-1:0] LAST_ALL = STEP_W'(TOTAL - 1);

  seq_state_e        state_q, state_d;
  logic [STEP_W-1:0] step_q, step_d;
  logic [STEP_W-1:0] last_q, last_d;
  logic              scan_q, scan_d;
  logic              launch_en, at_last;

  always_comb begin
    state_d   = state_q;
    step_d    = step_q;
    last_d    = last_q;
    scan_d    = scan_q;
    seq_start = 1'b0;
    seq_end   = 1'b0;
    done_acc  = 1'b0;
    launch_en = 1'b0;
    at_last   = (step_q == last_q);
    case (state_q)
      SQ_IDLE: begin
        if (st_en && st_start && (scan_mode || (step_sel <= LAST_ALL))) begin
          launch_en = 1'b1;
          state_d   = SQ_CONV;
          scan_d    = scan_mode;
          last_d    = alg_with_cap ? LAST_ALL : LAST_SUP;
          step_d    = scan_mode ? '0 : step_sel;
          seq_start = 1'b1;
        end
      end
      SQ_CONV: begin
        if (!st_en) begin
          state_d = SQ_IDLE;
        end else if (conv_done) begin
          done_acc = 1'b1;
          seq_end  = !scan_q || at_last;
          if (scan_q && st_start) begin
            step_d    = at_last ? '0 : step_q + 1'b1;
            seq_start = at_last;
          end else begin
            state_d = SQ_IDLE;
          end
        end
      end
      default: state_d = SQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SQ_IDLE;
      step_q  <= '0;
      last_q  <= '0;
      scan_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      step_q  <= step_d;
      if (launch_en) begin
        last_q <= last_d;
        scan_q <= scan_d;
      end
    end
  end

  assign conv_req  = (state_q == SQ_CONV);
  assign conv_step = step_q;
endmodule

// File: rtl/bist_seq_wdog.sv
module bist_seq_wdog #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             abort,
  input  logic             seq_start,
  input  logic             seq_end,
  input  logic [CNT_W-1:0] limit,
  output logic             err
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             armed_q, armed_d;
  logic             err_q, err_d;

  always_comb begin
    cnt_d   = cnt_q;
    armed_d = armed_q;
    err_d   = err_q;
    if (abort) begin
      armed_d = 1'b0;
      err_d   = 1'b0;
    end else if (seq_start) begin
      cnt_d   = limit;
      armed_d = (limit != '0);
    end else if (seq_end) begin
      armed_d = 1'b0;
    end else if (armed_q) begin
      if (cnt_q == '0) begin
        err_d   = 1'b1;
        armed_d = 1'b0;
      end else begin
        cnt_d = cnt_q - 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      armed_q <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      cnt_q   <= cnt_d;
      armed_q <= armed_d;
      err_q   <= err_d;
    end
  end

  assign err = err_q;
endmodule

// File: rtl/bist_step_sequencer.sv
module bist_step_sequencer #(
  parameter int N_SUPPLY = 3,
  parameter int N_CAP    = 12,
  parameter int WDOG_W   = 16,
  localparam int STEP_W  = $clog2(N_SUPPLY + N_CAP + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              st_en,
  input  logic              st_start,
  input  logic              scan_mode,
  input  logic              alg_with_cap,
  input  logic [STEP_W-1:0] step_sel,
  input  logic              eoc_clr,
  input  logic [WDOG_W-1:0] wdog_limit,
  input  logic              conv_done,
  output logic              conv_req,
  output logic [STEP_W-1:0] conv_step,
  output logic              eoc_flag,
  output logic              wdog_err
);
  logic rst_sync_n;
  logic done_acc, seq_start, seq_end;
  logic eoc_q, eoc_d;

  bist_seq_rstsync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  bist_seq_ctrl #(
    .N_SUPPLY (N_SUPPLY),
    .N_CAP    (N_CAP),
    .STEP_W   (STEP_W)
  ) u_ctrl (
    .clk          (clk),
    .rst_n        (rst_sync_n),
    .st_en        (st_en),
    .st_start     (st_start),
    .scan_mode    (scan_mode),
    .alg_with_cap (alg_with_cap),
    .step_sel     (step_sel),
    .conv_done    (conv_done),
    .conv_req     (conv_req),
    .conv_step    (conv_step),
    .done_acc     (done_acc),
    .seq_start    (seq_start),
    .seq_end      (seq_end)
  );

  bist_seq_wdog #(
    .CNT_W (WDOG_W)
  ) u_wdog (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .abort     (!st_en),
    .seq_start (seq_start),
    .seq_end   (seq_end),
    .limit     (wdog_limit),
    .err       (wdog_err)
  );

  always_comb begin
    eoc_d = eoc_q;
    if (eoc_clr)  eoc_d = 1'b0;
    if (done_acc) eoc_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) eoc_q <= 1'b0;
    else             eoc_q <= eoc_d;
  end

  assign eoc_flag = eoc_q;
endmodule

// File: rtl/bist_seq_chk.sv
module bist_seq_chk #(
  parameter int STEP_W = 4,
  parameter int LAST   = 14
) (
  input logic              clk,
  input logic              rst_n,
  input logic              st_en,
  input logic              eoc_clr,
  input logic              conv_done,
  input logic              conv_req,
  input logic [STEP_W-1:0] conv_step,
  input logic              eoc_flag,
  input logic              wdog_err
);
  a_r2_hold_pending: assert property (@(posedge clk) disable iff (!rst_n)
    (conv_req && !conv_done && st_en) |=> (conv_req && $stable(conv_step)));

  a_r2_step_range: assert property (@(posedge clk) disable iff (!rst_n)
    conv_req |-> (conv_step <= STEP_W'(LAST)));

  a_r8_abort_req: assert property (@(posedge clk) disable iff (!rst_n)
    !st_en |=> !conv_req);

  a_r8_abort_err: assert property (@(posedge clk) disable iff (!rst_n)
    !st_en |=> !wdog_err);

  a_r9_eoc_set: assert property (@(posedge clk) disable iff (!rst_n)
    (conv_req && conv_done && st_en) |=> eoc_flag);

  a_r9_eoc_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (eoc_clr && !(conv_req && conv_done && st_en)) |=> !eoc_flag);

  a_r9_eoc_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (eoc_flag && !eoc_clr) |=> eoc_flag);
endmodule

bind bist_step_sequencer bist_seq_chk #(
  .STEP_W (STEP_W),
  .LAST   (N_SUPPLY + N_CAP - 1)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .st_en     (st_en),
  .eoc_clr   (eoc_clr),
  .conv_done (conv_done),
  .conv_req  (conv_req),
  .conv_step (conv_step),
  .eoc_flag  (eoc_flag),
  .wdog_err  (wdog_err)
);

// File: tb/bist_step_sequencer_tb.sv
module bist_step_sequencer_tb;
  logic        clk;
  logic        rst_n;
  logic        st_en, st_start, scan_mode, alg_with_cap, eoc_clr, conv_done;
  logic [3:0]  step_sel;
  logic [15:0] wdog_limit;
  logic        conv_req, eoc_flag, wdog_err;
  logic [3:0]  conv_step;
  int          n_chk = 0;
  int          n_fail = 0;

  // {step_sel, extra wait cycles}
  localparam logic [7:0] VEC [6] = '{8'h01, 8'h13, 8'h20, 8'h32, 8'h91, 8'hE4};

  bist_step_sequencer u_dut (
    .clk(clk), .rst_n(rst_n), .st_en(st_en), .st_start(st_start),
    .scan_mode(scan_mode), .alg_with_cap(alg_with_cap), .step_sel(step_sel),
    .eoc_clr(eoc_clr), .wdog_limit(wdog_limit), .conv_done(conv_done),
    .conv_req(conv_req), .conv_step(conv_step), .eoc_flag(eoc_flag),
    .wdog_err(wdog_err)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  task automatic clear_eoc();
    eoc_clr = 1'b1;
    @(negedge clk);
    eoc_clr = 1'b0;
  endtask

  task automatic one_shot_launch(input logic [3:0] s);
    scan_mode = 1'b0;
    step_sel  = s;
    st_start  = 1'b1;
    @(negedge clk);
    st_start  = 1'b0;
  endtask

  task automatic run_scan(input logic cap, input int n);
    int period;
    period = cap ? 15 : 3;
    scan_mode    = 1'b1;
    alg_with_cap = cap;
    st_start     = 1'b1;
    @(negedge clk);
    for (int i = 0; i < n; i++) begin
      chk(cap ? "R6 step" : "R5 step", conv_step, i % period);
      conv_done = 1'b1;
      @(negedge clk);
      conv_done = 1'b0;
      @(negedge clk);
    end
    st_start  = 1'b0;
    conv_done = 1'b1;
    @(negedge clk);
    conv_done = 1'b0;
    chk("R7 stop", conv_req, 0);
    clear_eoc();
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    n_fail++;
    n_chk++;
    $display("FAIL watchdog actual=hung expected=done");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; st_en = 1'b0; st_start = 1'b0; scan_mode = 1'b0;
    alg_with_cap = 1'b0; eoc_clr = 1'b0; conv_done = 1'b0;
    step_sel = 4'd0; wdog_limit = 16'd0;
    repeat (3) @(negedge clk);
    chk("R1 req", conv_req, 0);
    chk("R1 eoc", eoc_flag, 0);
    chk("R1 err", wdog_err, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R8: start ignored while disabled
    one_shot_launch(4'd1);
    chk("R8 disabled start", conv_req, 0);
    st_en = 1'b1;
    @(negedge clk);

    // R12: stray done while idle
    conv_done = 1'b1;
    @(negedge clk);
    conv_done = 1'b0;
    chk("R12 stray done", eoc_flag, 0);

    // R3 vector walk
    foreach (VEC[k]) begin
      one_shot_launch(VEC[k][7:4]);
      chk("R3 req", conv_req, 1);
      chk("R3 step", conv_step, VEC[k][7:4]);
      repeat (VEC[k][3:0]) @(negedge clk);
      chk("R2 held", conv_req, 1);
      chk("R2 step held", conv_step, VEC[k][7:4]);
      conv_done = 1'b1;
      @(negedge clk);
      conv_done = 1'b0;
      chk("R3 idle", conv_req, 0);
      chk("R9 eoc set", eoc_flag, 1);
      clear_eoc();
      chk("R9 eoc clr", eoc_flag, 0);
    end

    // R4 out-of-range selection
    one_shot_launch(4'd15);
    chk("R4 ignored", conv_req, 0);

    // R10 start during conversion, then R9 set-wins
    one_shot_launch(4'd5);
    step_sel = 4'd7;
    st_start = 1'b1;
    @(negedge clk);
    st_start = 1'b0;
    chk("R10 step", conv_step, 5);
    conv_done = 1'b1;
    @(negedge clk);
    conv_done = 1'b0;
    @(negedge clk);
    chk("R10 no relaunch", conv_req, 0);
    one_shot_launch(4'd2);
    conv_done = 1'b1;
    eoc_clr   = 1'b1;
    @(negedge clk);
    conv_done = 1'b0;
    eoc_clr   = 1'b0;
    chk("R9 set wins", eoc_flag, 1);
    clear_eoc();

    // R5 / R6 / R7 scan
    run_scan(1'b0, 7);
    run_scan(1'b1, 17);

    // R11 timeout at edge L+1
    wdog_limit = 16'd5;
    one_shot_launch(4'd0);
    repeat (5) @(negedge clk);
    chk("R11 before expiry", wdog_err, 0);
    @(negedge clk);
    chk("R11 expiry", wdog_err, 1);
    st_en = 1'b0;
    @(negedge clk);
    chk("R8 abort req", conv_req, 0);
    chk("R8 abort err", wdog_err, 0);
    st_en = 1'b1;
    @(negedge clk);

    // R11 in-time completion
    one_shot_launch(4'd0);
    repeat (4) @(negedge clk);
    conv_done = 1'b1;
    @(negedge clk);
    conv_done = 1'b0;
    repeat (8) @(negedge clk);
    chk("R11 in time", wdog_err, 0);
    clear_eoc();

    // R11 limit zero disables
    wdog_limit = 16'd0;
    one_shot_launch(4'd3);
    repeat (20) @(negedge clk);
    chk("R11 disabled", wdog_err, 0);
    conv_done = 1'b1;
    @(negedge clk);
    conv_done = 1'b0;
    clear_eoc();

    finish_run();
  end
endmodule